// File: doc/BRIEF.md
# Low-Voltage Reset Sequencer

This block produces the internal chip reset. It takes two requests. The first is an active-low external reset pin. The second is a flag from the supply monitor that says the supply is inside the low-voltage band. The supply flag is trusted only when it stays up for a minimum time. That time is measured in pulses of a free-running reference tick, so a short supply dip cannot reset the chip. A qualified supply event and the external pin are ORed together.

When every request has gone away, a settling timer counts system clock cycles so that the oscillator can stabilise. Normal operation is released only when the count finishes. If any request returns during the count, the count starts again from zero. The block drives two registered outputs that are always complements of each other: a reset and a running flag. A synchronous, active-high power-on input resets the sequencer itself.

Top module: `lvr_reset_seq`

## Requirements
- R1: While `por_rst` is high, `chip_rst` is 1 and `running` is 0 from the next clock edge on.
- R2: `ext_rst_n` passes through a two-flop synchronizer. A low level on it that covers at least one rising clock edge drives `running` to 0 no later than the third rising edge after the level is applied.
- R3: A high level on `lv_flag` during which fewer than `QUAL_TICKS` reference ticks arrive causes no reset. `running` stays 1.
- R4: When `lv_flag` stays high through `QUAL_TICKS` ticks, `running` is 0 three clock edges after the edge that captured the last required tick. It stays 0 while `lv_flag` remains high.
- R5: The tick count used for qualification returns to zero whenever `lv_flag` drops. Two separate sub-threshold episodes whose combined ticks reach `QUAL_TICKS` therefore cause no reset.
- R6: After the external request clears, `running` rises exactly `SETTLE_CYCLES`+3 rising edges after the pin returns high. After a qualified supply event, it rises `SETTLE_CYCLES`+4 edges after `lv_flag` returns low. In both cases it is still 0 one edge earlier.
- R7: A request that returns while the settling count is running restarts that count. The release time is then measured from the last request.
- R8: `chip_rst` is always the complement of `running`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_rst | input | 1 | Synchronous active-high reset of the sequencer |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| lv_flag | input | 1 | Supply-monitor flag, high while supply is in the low band, asynchronous |
| ref_tick | input | 1 | One-cycle pulse from the free-running timing reference |
| chip_rst | output | 1 | Internal reset, active high, registered |
| running | output | 1 | High once normal operation is released, registered |

## Verification
The bench builds the block with `QUAL_TICKS` = 8 and `SETTLE_CYCLES` = 16 instead of the defaults of 1000 and 1024. With these values the qualification boundary can be reached tick by tick. The release edge can be checked exactly, one edge either side, for many pulses within a short run. Random external pulse widths, random restarts inside the settling window and random sub-threshold supply glitches are mixed with directed threshold cases.

// File: rtl/lvr_pkg.sv
package lvr_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/lvr_sync.sv
module lvr_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lvr_qualifier.sv
module lvr_qualifier #(
  parameter int unsigned QUAL_TICKS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic lv_s,
  input  logic tick,
  output logic lv_rst
);
  localparam int unsigned CW = lvr_pkg::cnt_width(QUAL_TICKS);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !lv_s)              cnt <= '0;
    else if (tick && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) lv_rst <= 1'b0;
    else     lv_rst <= lv_s && (cnt == LIMIT);
  end

  // R5: a dropped flag always clears the qualified request next cycle
  a_r5_drop_clears: assert property (@(posedge clk) disable iff (rst)
    !lv_s |=> !lv_rst);
  // R4: a qualified request only exists once the full tick count was seen
  a_r4_full_count: assert property (@(posedge clk) disable iff (rst)
    lv_rst |-> $past(cnt) == LIMIT);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);
endmodule

// File: rtl/lvr_settle.sv
module lvr_settle #(
  parameter int unsigned SETTLE_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic chip_rst,
  output logic running
);
  localparam int unsigned CW = lvr_pkg::cnt_width(SETTLE_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt;
  logic          done;

  assign done = (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || req) cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || req) begin
      running  <= 1'b0;
      chip_rst <= 1'b1;
    end else begin
      running  <= done;
      chip_rst <= !done;
    end
  end

  // R7: any request stops normal operation on the next edge
  a_r7_req_holds: assert property (@(posedge clk) disable iff (rst)
    req |=> !running);
  // R6: release only after the full settling window
  a_r6_full_window: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> $past(cnt) == LIMIT);
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);
endmodule

// File: rtl/lvr_reset_seq.sv
module lvr_reset_seq #(
  parameter int unsigned QUAL_TICKS    = 1000,
  parameter int unsigned SETTLE_CYCLES = 1024
) (
  input  logic clk,
  input  logic por_rst,
  input  logic ext_rst_n,
  input  logic lv_flag,
  input  logic ref_tick,
  output logic chip_rst,
  output logic running
);
  logic ext_n_s;
  logic lv_s;
  logic lv_rst;
  logic req;

  lvr_sync #(.STAGES(lvr_pkg::SYNC_DEPTH), .RST_VAL(1'b0)) u_ext_sync (
    .clk(clk), .rst(por_rst), .d(ext_rst_n), .q(ext_n_s)
  );

  lvr_sync #(.STAGES(lvr_pkg::SYNC_DEPTH), .RST_VAL(1'b0)) u_lv_sync (
    .clk(clk), .rst(por_rst), .d(lv_flag), .q(lv_s)
  );

  lvr_qualifier #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk(clk), .rst(por_rst), .lv_s(lv_s), .tick(ref_tick), .lv_rst(lv_rst)
  );

  assign req = !ext_n_s || lv_rst;

  lvr_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst(por_rst), .req(req), .chip_rst(chip_rst), .running(running)
  );

  // R8: the two outputs never agree
  a_r8_complement: assert property (@(posedge clk) disable iff (por_rst)
    chip_rst != running);
  // R2: a synchronized external request forces reset
  a_r2_ext_forces: assert property (@(posedge clk) disable iff (por_rst)
    !ext_n_s |=> chip_rst);
  // R1: power-on reset holds the chip in reset
  a_r1_por_state: assert property (@(posedge clk)
    $past(por_rst) |-> (chip_rst && !running));
endmodule

// File: tb/lvr_reset_seq_test.sv
module lvr_reset_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int QT = 8;
  localparam int SC = 16;

  logic clk = 1'b0;
  logic por_rst = 1'b1;
  logic ext_rst_n = 1'b1;
  logic lv_flag = 1'b0;
  logic ref_tick = 1'b0;
  logic chip_rst, running;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvr_reset_seq #(.QUAL_TICKS(QT), .SETTLE_CYCLES(SC)) uut (
    .clk(clk), .por_rst(por_rst), .ext_rst_n(ext_rst_n), .lv_flag(lv_flag),
    .ref_tick(ref_tick), .chip_rst(chip_rst), .running(running)
  );

  function automatic int ext_release_edges();
    return SC + 3;
  endfunction

  function automatic int lv_release_edges();
    return SC + 4;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic exp_run);
    check(req, running, exp_run);
    check({req, "/R8"}, chip_rst, !exp_run);
  endtask

  task automatic check_release(input string req, input int edges);
    step(edges - 1);
    check_out(req, 1'b0);
    step(1);
    check_out(req, 1'b1);
  endtask

  task automatic ext_pulse(input int w);
    ext_rst_n = 1'b0;
    step(w);
    ext_rst_n = 1'b1;
  endtask

  task automatic tick();
    ref_tick = 1'b1;
    step(1);
    ref_tick = 1'b0;
    step(3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    step(3);
    check_out("R1", 1'b0);
    por_rst = 1'b0;
    check_release("R6 por", ext_release_edges());

    // R2 + R6: directed single-cycle external pulse
    ext_pulse(1);
    check_release("R2/R6", ext_release_edges());

    // R3: one tick short of the threshold
    lv_flag = 1'b1; step(3);
    for (int i = 0; i < QT - 1; i++) tick();
    check_out("R3", 1'b1);
    lv_flag = 1'b0; step(3);
    check_out("R3", 1'b1);

    // R5: two sub-threshold episodes together exceed the threshold
    lv_flag = 1'b1; step(3);
    for (int i = 0; i < QT - 1; i++) tick();
    lv_flag = 1'b0; step(3);
    lv_flag = 1'b1; step(3);
    for (int i = 0; i < QT - 1; i++) tick();
    check_out("R5", 1'b1);
    lv_flag = 1'b0; step(3);
    check_out("R5", 1'b1);

    // R4: full qualification
    lv_flag = 1'b1; step(3);
    for (int i = 0; i < QT - 1; i++) tick();
    check_out("R4 pre", 1'b1);
    tick();
    check_out("R4", 1'b0);
    tick(); step(5);
    check_out("R4 hold", 1'b0);
    lv_flag = 1'b0;
    check_release("R6 lv", lv_release_edges());

    // Random external pulses, some restarted mid-window (R7)
    for (int k = 0; k < 20; k++) begin
      int w;
      w = 1 + int'($urandom % 5);
      ext_pulse(w);
      if ($urandom % 2) begin
        int mid;
        mid = 2 + int'($urandom % (SC - 4));
        step(mid);
        check_out("R7 mid", 1'b0);
        ext_pulse(1 + int'($urandom % 3));
        check_release("R7", ext_release_edges());
      end else begin
        check_release("R2/R6 rand", ext_release_edges());
      end
    end

    // Random sub-threshold supply glitches (R3)
    for (int k = 0; k < 12; k++) begin
      int nt;
      nt = int'($urandom % QT);
      lv_flag = 1'b1; step(3);
      for (int i = 0; i < nt; i++) tick();
      lv_flag = 1'b0; step(4);
      check_out("R3 rand", 1'b1);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule